// File: doc/BRIEF.md
# Request Address and Capability Checker

This block sits on one port of a memory interconnect and classifies each request before it is routed. It compares the request address with a fixed table of slave regions. Each slave owns a few masked address sets, and a set may be strided, so its matching addresses need not be contiguous. The block also matches the request's source ID against a table of client ID ranges. It then reports, for each operation type, whether the selected slave accepts that operation at the requested transfer size. The size is given as a log2 byte count.

All tables are elaboration-time parameters. At elaboration the block rejects a table with a misaligned base, with sets of different slaves that overlap, with an invalid size range, or with address and source widths that disagree with the tables. Each request presented with a valid strobe produces one registered result one clock later.

Top module: `req_cap_checker`

## Requirements
- R1: An address falls in a set when the bits of (address XOR base) outside the set's mask are all zero. A slave is selected when any of its sets matches, which includes strided masks such as 0x0f0f. The slave select vector is one-hot, and the hit flag is high when a slave is selected.
- R2: An address that matches no set gives an all-zero slave vector, a low hit flag and all seven legal bits low.
- R3: Client c is selected when its range start <= ID < its range end. Ranges are half-open, and IDs outside every range give an all-zero client vector. Single-element ranges, aligned power-of-two ranges and arbitrary ranges all decode correctly.
- R4: Legal bit op (0 read, 1 full write, 2 partial write, 3 arithmetic atomic, 4 logical atomic, 5 cache acquire) is high when the selected slave's range for that operation has a nonzero minimum and log2(min) <= size <= log2(max). A range whose minimum equals its maximum accepts exactly one size.
- R5: An operation whose range minimum is 0 is never legal on that slave, whatever the size.
- R6: When every slave has the same range for an operation (read, in the default tables), the result for that operation is the shared range check gated only by the hit flag. It must equal the result of the per-slave check.
- R7: Legal bit 6 (hint) is high when the selected slave has its hint flag set. When every slave has the flag set, the bit is simply the hit flag.
- R8: Every result appears one clock after a request with the valid strobe high, and rsp_valid is high exactly in that cycle. After reset, rsp_valid and all outputs are 0, and idle cycles hold the last result with rsp_valid low.
- R9: A size above 12 (more than 4096 bytes) is never legal for operations 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| req_src | input | SRC_W | Request source ID |
| req_lg_size | input | LG_W | log2 of transfer size in bytes |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_slv_sel | output | N_SLV | One-hot selected slave |
| rsp_hit | output | 1 | Address matched a slave |
| rsp_cli_sel | output | N_CLI | One-hot selected client |
| rsp_legal | output | 7 | Per-operation legality, bit index = operation code |

## Verification
Every result of this block, whether slave select, hit, client select or any of the seven legal bits, is due exactly one clock after the request strobe. No result is due earlier or later. The bench drives each request just after a falling edge and computes the expected values from the parameter tables at that moment. At the next falling edge it checks rsp_valid in every cycle and the other fields whenever a request was pending, so every comparison lands one register stage after its stimulus. The stimulus includes strided hits and gaps, every ID range variant, and every size from 0 to 15.

// File: rtl/cap_pkg.sv
package cap_pkg;

   localparam int unsigned MAX_XFER = 4096;
   localparam int unsigned XFER_W   = 13;
   localparam int unsigned N_SZ_OP  = 6;
   localparam int unsigned N_OP     = 7;

   typedef enum logic [2:0] {
      OP_READ      = 3'd0,
      OP_WR_WHOLE  = 3'd1,
      OP_WR_MASKED = 3'd2,
      OP_AMO_ARITH = 3'd3,
      OP_AMO_LOGIC = 3'd4,
      OP_ACQ       = 3'd5,
      OP_HINT      = 3'd6
   } op_e;

   function automatic int unsigned lg2_of(input int unsigned v);
      int unsigned r;
      r = 0;
      for (int i = 0; i < 32; i++) if ((v >> i) == 1) r = i;
      return r;
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   localparam int unsigned DEF_SLV    = 3;
   localparam int unsigned DEF_SET    = 2;
   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_CLI    = 4;
   localparam int unsigned DEF_SRC_W  = 4;

   // [slave][set]
   localparam logic [2:0][1:0][15:0] DEF_BASE = {
      {16'h3000, 16'h8000},
      {16'h4000, 16'h1000},
      {16'h2000, 16'h0000}};
   localparam logic [2:0][1:0][15:0] DEF_MASK = {
      {16'h00ff, 16'h7fff},
      {16'h00ff, 16'h0f0f},
      {16'h0fff, 16'h0fff}};

   // [slave][op], op 5..0 = acquire, logic, arith, partial, full, read
   localparam logic [2:0][5:0][12:0] DEF_SZ_MIN = {
      {13'd0,  13'd8, 13'd0, 13'd1, 13'd1, 13'd1},
      {13'd0,  13'd0, 13'd0, 13'd0, 13'd4, 13'd1},
      {13'd64, 13'd4, 13'd4, 13'd1, 13'd1, 13'd1}};
   localparam logic [2:0][5:0][12:0] DEF_SZ_MAX = {
      {13'd0,  13'd8, 13'd0, 13'd4096, 13'd4096, 13'd64},
      {13'd0,  13'd0, 13'd0, 13'd0,    13'd4,    13'd64},
      {13'd64, 13'd8, 13'd8, 13'd64,   13'd64,   13'd64}};

   localparam logic [2:0] DEF_HINT = 3'b101;

   // [client], half-open [lo, hi)
   localparam logic [3:0][15:0] DEF_CLI_LO = {16'd8,  16'd1, 16'd4, 16'd0};
   localparam logic [3:0][15:0] DEF_CLI_HI = {16'd11, 16'd4, 16'd8, 16'd1};

endpackage

// File: rtl/cap_addr_decode.sv
module cap_addr_decode #(
   parameter int unsigned N_SLV  = 2,
   parameter int unsigned N_SET  = 1,
   parameter int unsigned ADDR_W = 8,
   parameter logic [N_SLV-1:0][N_SET-1:0][ADDR_W-1:0] BASE = '0,
   parameter logic [N_SLV-1:0][N_SET-1:0][ADDR_W-1:0] MASK = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_SLV-1:0]  sel
);
   for (genvar s = 0; s < N_SLV; s++) begin : g_slv
      logic [N_SET-1:0] set_hit;
      for (genvar k = 0; k < N_SET; k++) begin : g_set
         // bits the slave does not consume must equal the base
         assign set_hit[k] = ((addr ^ BASE[s][k]) & ~MASK[s][k]) == '0;
      end
      assign sel[s] = |set_hit;
   end
endmodule

// File: rtl/cap_src_decode.sv
module cap_src_decode #(
   parameter int unsigned N_CLI = 2,
   parameter int unsigned SRC_W = 2,
   parameter logic [N_CLI-1:0][15:0] LO = '0,
   parameter logic [N_CLI-1:0][15:0] HI = '0
) (
   input  logic [SRC_W-1:0] src,
   output logic [N_CLI-1:0] sel
);
   for (genvar c = 0; c < N_CLI; c++) begin : g_cli
      localparam int unsigned START = int'(LO[c]);
      localparam int unsigned STOP  = int'(HI[c]);
      localparam int unsigned SPAN  = STOP - START;
      if (SPAN == 1) begin : g_eq
         assign sel[c] = (src == SRC_W'(START));
      end else if (cap_pkg::is_pow2(SPAN) && (START % SPAN) == 0) begin : g_msk
         assign sel[c] = ((src ^ SRC_W'(START)) & ~SRC_W'(SPAN - 1)) == '0;
      end else if (START == 0) begin : g_cmp_lo0
         assign sel[c] = ({1'b0, src} < (SRC_W+1)'(STOP));
      end else begin : g_cmp
         assign sel[c] = ({1'b0, src} >= (SRC_W+1)'(START)) &&
                         ({1'b0, src} <  (SRC_W+1)'(STOP));
      end
   end
endmodule

// File: rtl/cap_size_legal.sv
module cap_size_legal #(
   parameter int unsigned N_SLV = 2,
   parameter int unsigned LG_W  = 4,
   parameter logic [N_SLV-1:0][cap_pkg::XFER_W-1:0] MIN_B = '0,
   parameter logic [N_SLV-1:0][cap_pkg::XFER_W-1:0] MAX_B = '0
) (
   input  logic [N_SLV-1:0] sel,
   input  logic [LG_W-1:0]  lg,
   output logic             ok
);
   function automatic bit all_same();
      bit r;
      r = 1'b1;
      for (int s = 1; s < int'(N_SLV); s++)
         if (MIN_B[s] != MIN_B[0] || MAX_B[s] != MAX_B[0]) r = 1'b0;
      return r;
   endfunction

   localparam bit          UNIFORM = all_same();
   localparam int unsigned N_CHK   = UNIFORM ? 1 : N_SLV;

   logic [N_CHK-1:0] in_range;

   for (genvar s = 0; s < N_CHK; s++) begin : g_chk
      localparam int unsigned LO = cap_pkg::lg2_of(int'(MIN_B[s]));
      localparam int unsigned HI = cap_pkg::lg2_of(int'(MAX_B[s]));
      if (MIN_B[s] == '0) begin : g_none
         assign in_range[s] = 1'b0;
      end else if (LO == HI) begin : g_one
         assign in_range[s] = (lg == LG_W'(LO));
      end else if (LO == 0) begin : g_upto
         assign in_range[s] = (lg <= LG_W'(HI));
      end else begin : g_span
         assign in_range[s] = (lg >= LG_W'(LO)) && (lg <= LG_W'(HI));
      end
   end

   if (UNIFORM) begin : g_shared
      assign ok = in_range[0] & (|sel);
   end else begin : g_perslv
      assign ok = |(sel & in_range);
   end
endmodule

// File: rtl/req_cap_checker.sv
module req_cap_checker #(
   parameter int unsigned N_SLV  = cap_pkg::DEF_SLV,
   parameter int unsigned N_SET  = cap_pkg::DEF_SET,
   parameter int unsigned ADDR_W = cap_pkg::DEF_ADDR_W,
   parameter int unsigned N_CLI  = cap_pkg::DEF_CLI,
   parameter int unsigned SRC_W  = cap_pkg::DEF_SRC_W,
   parameter int unsigned LG_W   = 4,
   parameter logic [N_SLV-1:0][N_SET-1:0][ADDR_W-1:0] REG_BASE = cap_pkg::DEF_BASE,
   parameter logic [N_SLV-1:0][N_SET-1:0][ADDR_W-1:0] REG_MASK = cap_pkg::DEF_MASK,
   parameter logic [N_SLV-1:0][cap_pkg::N_SZ_OP-1:0][cap_pkg::XFER_W-1:0] SZ_MIN = cap_pkg::DEF_SZ_MIN,
   parameter logic [N_SLV-1:0][cap_pkg::N_SZ_OP-1:0][cap_pkg::XFER_W-1:0] SZ_MAX = cap_pkg::DEF_SZ_MAX,
   parameter logic [N_SLV-1:0] HINT_EN = cap_pkg::DEF_HINT,
   parameter logic [N_CLI-1:0][15:0] CLI_LO = cap_pkg::DEF_CLI_LO,
   parameter logic [N_CLI-1:0][15:0] CLI_HI = cap_pkg::DEF_CLI_HI
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [SRC_W-1:0]          req_src,
   input  logic [LG_W-1:0]           req_lg_size,
   output logic                      rsp_valid,
   output logic [N_SLV-1:0]          rsp_slv_sel,
   output logic                      rsp_hit,
   output logic [N_CLI-1:0]          rsp_cli_sel,
   output logic [cap_pkg::N_OP-1:0]  rsp_legal
);
   localparam int unsigned XW = cap_pkg::XFER_W;

   // ---------------- elaboration-time table checks ----------------
   function automatic longint unsigned top_addr();
      longint unsigned r;
      r = 0;
      for (int s = 0; s < int'(N_SLV); s++)
         for (int k = 0; k < int'(N_SET); k++)
            if (longint'(REG_BASE[s][k] | REG_MASK[s][k]) > r)
               r = longint'(REG_BASE[s][k] | REG_MASK[s][k]);
      return r;
   endfunction

   function automatic int unsigned top_src();
      int unsigned r;
      r = 1;
      for (int c = 0; c < int'(N_CLI); c++)
         if (int'(CLI_HI[c]) > r) r = int'(CLI_HI[c]);
      return r;
   endfunction

   localparam longint unsigned ADDR_TOP = top_addr();
   localparam int unsigned     SRC_TOP  = top_src();

   if (ADDR_W != $clog2(ADDR_TOP + 1)) begin : g_bad_aw
      $error("address width does not fit region table");
   end
   if (SRC_W != $clog2(SRC_TOP)) begin : g_bad_sw
      $error("source width does not fit client table");
   end
   if (LG_W < $clog2(cap_pkg::lg2_of(cap_pkg::MAX_XFER) + 1)) begin : g_bad_lw
      $error("size field too narrow");
   end

   for (genvar s = 0; s < N_SLV; s++) begin : g_chk_slv
      for (genvar k = 0; k < N_SET; k++) begin : g_chk_set
         if ((REG_BASE[s][k] & REG_MASK[s][k]) != '0) begin : g_misalign
            $error("region base overlaps its mask");
         end
         for (genvar t = s + 1; t < N_SLV; t++) begin : g_other
            for (genvar j = 0; j < N_SET; j++) begin : g_oset
               if ((~(REG_MASK[s][k] | REG_MASK[t][j]) &
                    (REG_BASE[s][k] ^ REG_BASE[t][j])) == '0) begin : g_ovl
                  $error("regions of two slaves overlap");
               end
            end
         end
      end
      for (genvar o = 0; o < cap_pkg::N_SZ_OP; o++) begin : g_chk_sz
         localparam int unsigned MN = int'(SZ_MIN[s][o]);
         localparam int unsigned MX = int'(SZ_MAX[s][o]);
         if (MX > cap_pkg::MAX_XFER || MN > MX || ((MN == 0) != (MX == 0)) ||
             (MN != 0 && !(cap_pkg::is_pow2(MN) && cap_pkg::is_pow2(MX)))) begin : g_bad_sz
            $error("invalid transfer size range");
         end
      end
   end

   for (genvar c = 0; c < N_CLI; c++) begin : g_chk_cli
      if (CLI_HI[c] <= CLI_LO[c]) begin : g_empty
         $error("empty client ID range");
      end
   end

   // ---------------- decode ----------------
   function automatic logic [N_SLV-1:0][XW-1:0] op_col(
      input logic [N_SLV-1:0][cap_pkg::N_SZ_OP-1:0][XW-1:0] tbl, input int op);
      logic [N_SLV-1:0][XW-1:0] r;
      for (int s = 0; s < int'(N_SLV); s++) r[s] = tbl[s][op];
      return r;
   endfunction

   logic [N_SLV-1:0]         slv_c;
   logic [N_CLI-1:0]         cli_c;
   logic [cap_pkg::N_OP-1:0] legal_c;
   logic                     hit_c;

   cap_addr_decode #(
      .N_SLV (N_SLV), .N_SET (N_SET), .ADDR_W (ADDR_W),
      .BASE  (REG_BASE), .MASK (REG_MASK)
   ) u_addr (
      .addr (req_addr),
      .sel  (slv_c)
   );

   cap_src_decode #(
      .N_CLI (N_CLI), .SRC_W (SRC_W), .LO (CLI_LO), .HI (CLI_HI)
   ) u_src (
      .src (req_src),
      .sel (cli_c)
   );

   assign hit_c = |slv_c;

   for (genvar o = 0; o < cap_pkg::N_SZ_OP; o++) begin : g_op
      cap_size_legal #(
         .N_SLV (N_SLV), .LG_W (LG_W),
         .MIN_B (op_col(SZ_MIN, o)), .MAX_B (op_col(SZ_MAX, o))
      ) u_sz (
         .sel (slv_c),
         .lg  (req_lg_size),
         .ok  (legal_c[o])
      );
   end

   if (&HINT_EN) begin : g_hint_all
      assign legal_c[cap_pkg::OP_HINT] = hit_c;
   end else begin : g_hint_sel
      assign legal_c[cap_pkg::OP_HINT] = |(slv_c & HINT_EN);
   end

   // ---------------- result register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_slv_sel <= '0;
         rsp_hit     <= 1'b0;
         rsp_cli_sel <= '0;
         rsp_legal   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_slv_sel <= slv_c;
            rsp_hit     <= hit_c;
            rsp_cli_sel <= cli_c;
            rsp_legal   <= legal_c;
         end
      end
   end
endmodule

// File: rtl/req_cap_checker_sva.sv
module req_cap_checker_sva #(
   parameter int unsigned N_SLV = 3,
   parameter int unsigned N_CLI = 4,
   parameter int unsigned LG_W  = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic [LG_W-1:0]          req_lg_size,
   input logic                     rsp_valid,
   input logic [N_SLV-1:0]         rsp_slv_sel,
   input logic                     rsp_hit,
   input logic [N_CLI-1:0]         rsp_cli_sel,
   input logic [cap_pkg::N_OP-1:0] rsp_legal
);
   p_slv_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0(rsp_slv_sel));

   p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_legal == '0));

   p_cli_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $onehot0(rsp_cli_sel));

   p_resp_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_size_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && (|rsp_legal[cap_pkg::N_SZ_OP-1:0])) |->
         ($past(req_lg_size) <= LG_W'(12)));
endmodule

bind req_cap_checker req_cap_checker_sva #(
   .N_SLV (N_SLV), .N_CLI (N_CLI), .LG_W (LG_W)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_lg_size (req_lg_size),
   .rsp_valid   (rsp_valid),
   .rsp_slv_sel (rsp_slv_sel),
   .rsp_hit     (rsp_hit),
   .rsp_cli_sel (rsp_cli_sel),
   .rsp_legal   (rsp_legal)
);

// File: tb/req_cap_checker_tb_top.sv
module req_cap_checker_tb_top;
   import cap_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NS = DEF_SLV;
   localparam int NK = DEF_SET;
   localparam int NC = DEF_CLI;
   localparam int AW = DEF_ADDR_W;
   localparam int SW = DEF_SRC_W;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [SW-1:0] req_src = '0;
   logic [LW-1:0] req_lg_size = '0;
   logic          rsp_valid;
   logic [NS-1:0] rsp_slv_sel;
   logic          rsp_hit;
   logic [NC-1:0] rsp_cli_sel;
   logic [N_OP-1:0] rsp_legal;

   always #(CLK_PERIOD/2) clk = ~clk;

   req_cap_checker dut_i (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
      .req_addr (req_addr), .req_src (req_src), .req_lg_size (req_lg_size),
      .rsp_valid (rsp_valid), .rsp_slv_sel (rsp_slv_sel), .rsp_hit (rsp_hit),
      .rsp_cli_sel (rsp_cli_sel), .rsp_legal (rsp_legal)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // expectation queue: one entry per cycle, built when the input is driven
   logic            q_v[$];
   logic [NS-1:0]   q_slv[$];
   logic [NC-1:0]   q_cli[$];
   logic [N_OP-1:0] q_leg[$];
   int              q_sidx[$];
   int              q_lg[$];

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic [AW-1:0] a, input logic [SW-1:0] src,
                        input int lg);
      logic [NS-1:0]   slv;
      logic [NC-1:0]   cli;
      logic [N_OP-1:0] leg;
      int              sidx;
      slv = '0; cli = '0; leg = '0; sidx = -1;
      for (int s = 0; s < NS; s++)
         for (int k = 0; k < NK; k++)
            if (((a ^ DEF_BASE[s][k]) & ~DEF_MASK[s][k]) == 16'h0) begin
               slv[s] = 1'b1;
               sidx = s;
            end
      for (int c = 0; c < NC; c++)
         if (int'(src) >= int'(DEF_CLI_LO[c]) && int'(src) < int'(DEF_CLI_HI[c]))
            cli[c] = 1'b1;
      if (sidx >= 0) begin
         for (int o = 0; o < N_SZ_OP; o++) begin
            longint bytes = longint'(1) << lg;
            longint mn = longint'(DEF_SZ_MIN[sidx][o]);
            longint mx = longint'(DEF_SZ_MAX[sidx][o]);
            leg[o] = (mn != 0) && (bytes >= mn) && (bytes <= mx);
         end
         leg[N_OP-1] = DEF_HINT[sidx];
      end
      q_slv.push_back(slv); q_cli.push_back(cli); q_leg.push_back(leg);
      q_sidx.push_back(sidx); q_lg.push_back(lg);
   endtask

   function automatic string leg_tag(input int sidx, input int o, input int lg);
      if (sidx < 0) return "R2";
      if (o == N_OP-1) return "R7";
      if (DEF_SZ_MIN[sidx][o] == 13'd0) return "R5";
      if (lg > 12) return "R9";
      if (o == 0) return "R6";
      return "R4";
   endfunction

   // compare the result of the request driven one cycle earlier
   task automatic compare_out();
      logic v;
      v = q_v.pop_front();
      chk("R8", "rsp_valid", 32'(rsp_valid), 32'(v));
      if (v) begin
         logic [NS-1:0]   es;
         logic [NC-1:0]   ec;
         logic [N_OP-1:0] el;
         int              si, lg;
         es = q_slv.pop_front(); ec = q_cli.pop_front(); el = q_leg.pop_front();
         si = q_sidx.pop_front(); lg = q_lg.pop_front();
         chk("R1", "slv_sel", 32'(rsp_slv_sel), 32'(es));
         chk(si < 0 ? "R2" : "R1", "hit", 32'(rsp_hit), 32'(si >= 0));
         chk("R3", "cli_sel", 32'(rsp_cli_sel), 32'(ec));
         for (int o = 0; o < N_OP; o++)
            chk(leg_tag(si, o, lg), $sformatf("legal[%0d]", o),
                32'(rsp_legal[o]), 32'(el[o]));
      end
   endtask

   task automatic step(input logic v, input logic [AW-1:0] a,
                       input logic [SW-1:0] s, input int lg);
      @(negedge clk);
      compare_out();
      req_valid = v; req_addr = a; req_src = s; req_lg_size = LW'(lg);
      q_v.push_back(v);
      if (v) model(a, s, lg);
   endtask

   localparam int N_DIR = 13;
   logic [AW-1:0] dir_addr [N_DIR] = '{
      16'h0000, 16'h0fff, 16'h2abc, 16'h1000, 16'h100f, 16'h1f05, 16'h1010,
      16'h4055, 16'h3080, 16'h8000, 16'hffff, 16'h5000, 16'h3100};

   initial begin
      repeat (4) @(negedge clk);
      // reset state, R8
      chk("R8", "reset rsp_valid", 32'(rsp_valid), 32'd0);
      chk("R8", "reset slv_sel", 32'(rsp_slv_sel), 32'd0);
      chk("R8", "reset legal", 32'(rsp_legal), 32'd0);
      rst_n = 1'b1;
      q_v.push_back(1'b0);
      // directed: every region corner, gap, size and ID
      for (int i = 0; i < N_DIR; i++)
         for (int lg = 0; lg < 16; lg++)
            step(1'b1, dir_addr[i], SW'((i + lg) % 16), lg);
      // idle gap: outputs held, rsp_valid low (R8)
      step(1'b0, '0, '0, 0);
      step(1'b0, '0, '0, 0);
      // random traffic with idle cycles
      for (int n = 0; n < 3000; n++) begin
         logic [AW-1:0] a;
         a = AW'($urandom);
         if (n % 3 == 0) a = dir_addr[$urandom % N_DIR] ^ AW'($urandom % 16);
         step(($urandom % 4) != 0, a, SW'($urandom), int'($urandom % 16));
      end
      step(1'b0, '0, '0, 0);
      @(negedge clk);
      compare_out();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule